// File: doc/BRIEF.md
# Regulated H-Bridge PWM Controller

This block drives the four switch enables of a full bridge that powers a brushed DC motor. A free-running period counter forms the PWM timebase, and one select bit picks the period. A per-period duty value turns the result into an on-phase and an off-phase. In the on-phase the bridge pushes current through the winding in the commanded direction. In the off-phase both low-side switches conduct, so the winding current circulates through them instead of decaying through the body diodes.

The duty has two sources. In manual mode it is a 6-bit value that software programs. In regulation mode a closed loop moves the duty by one step per period, so that a digitised average of the bridge output voltage tracks a digitised target. If the target is above the measured supply, the loop freezes and the bridge runs fully on. The direction command comes either from two external pins or from two register bits. The duty actually in use is always visible on a readback output.

Top module: `hbridge_pwm_ctrl`

## Requirements
- R1: The period counter counts 0 to P-1, with P = 200 clocks when `freq_sel` is 0 and P = 400 when it is 1. A new `freq_sel` value takes effect at the next period boundary. Reset selects P = 200.
- R2: For a duty D below 63, `pwm_on` is high for the first floor(D*P/64) counts of each period and low for the rest. D = 31 gives 96 of 200 and 193 of 400.
- R3: A duty of 63 keeps `pwm_on` high for the whole period. A duty of 0 keeps it low.
- R4: `duty_rd` changes only on the clock edge that ends a period. In manual mode it then loads `man_duty`.
- R5: With `dir_src` at 0 the direction pair is `pin_dir`. With `dir_src` at 1 it is `reg_dir`. Bit 1 is the first bridge input and bit 0 is the second.
- R6: In the on-phase, direction 10 (forward) sets `hs_a` and `ls_b`, and direction 01 (reverse) sets `hs_b` and `ls_a`.
- R7: In the off-phase, forward and reverse both set `ls_a` and `ls_b` and clear both high sides.
- R8: Direction 00 (coast) clears all four enables. Direction 11 (brake) sets only `ls_a` and `ls_b`, whatever the PWM phase.
- R9: In regulation mode the first `smp_valid` sample of a period is compared. Average below target means up, above target means down, equal means hold. At the next period end the duty moves one LSB in that direction. A period with no sample holds the duty.
- R10: Loop steps saturate at 0 and at 63.
- R11: A valid sample with target greater than supply forces the applied duty to 63 from the next period end, and the loop value is frozen. After a sample with target not above supply, stepping resumes from the frozen value.
- R12: In regulation mode `man_duty` has no effect. On entering regulation the loop starts from the duty last applied in manual mode.
- R13: During and right after reset `duty_rd` is 0 and `pwm_on` is 0.
- R14: No side ever has its high and low enables set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 1 | Period select: 0 gives 200 clocks, 1 gives 400 |
| reg_mode | input | 1 | 1 selects closed-loop regulation, 0 selects manual duty |
| man_duty | input | 6 | Programmed duty used in manual mode |
| dir_src | input | 1 | Direction source: 0 selects the pins, 1 selects the register bits |
| pin_dir | input | 2 | Direction pair from the external pins |
| reg_dir | input | 2 | Direction pair from the register bits |
| smp_valid | input | 1 | Strobe marking valid voltage samples |
| vout_avg | input | 10 | Averaged bridge output voltage sample |
| vsupply | input | 10 | Supply voltage sample |
| vtarget | input | 10 | Target output voltage |
| hs_a | output | 1 | High-side enable, side A |
| ls_a | output | 1 | Low-side enable, side A |
| hs_b | output | 1 | High-side enable, side B |
| ls_b | output | 1 | Low-side enable, side B |
| pwm_on | output | 1 | PWM phase, 1 during the on-time |
| duty_rd | output | 6 | Duty currently applied |

## Verification
A wrong period count or a wrong on-count shifts the `pwm_on` edges, and a per-cycle comparison shows this within one period. A wrong loop step, a missed saturation or a stale fallback flag shows as a wrong `duty_rd` on the first cycle after the next period end. Direction decoding errors appear at once on the four enables, because they follow the direction inputs combinationally. Long random runs cross all modes and directions, while directed sequences pin the step, saturation and fallback cases to exact period edges.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

  typedef enum logic [1:0] {
    DIR_COAST = 2'b00,
    DIR_REV   = 2'b01,
    DIR_FWD   = 2'b10,
    DIR_BRAKE = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gates_t;

  // on-time length in clocks: duty * period / 2**duty_w
  function automatic logic [15:0] on_count(input logic [7:0] duty,
                                           input logic [15:0] per,
                                           input int unsigned duty_w);
    logic [31:0] prod;
    prod = 32'(duty) * 32'(per);
    return 16'(prod >> duty_w);
  endfunction

  function automatic step_e cmp_step(input logic [15:0] avg,
                                     input logic [15:0] tgt);
    if (avg < tgt)      return STEP_UP;
    else if (avg > tgt) return STEP_DOWN;
    else                return STEP_HOLD;
  endfunction

  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input step_e st,
                                          input logic [7:0] maxv);
    logic [7:0] r;
    r = cur;
    if (st == STEP_UP && cur < maxv)      r = cur + 8'd1;
    if (st == STEP_DOWN && cur != 8'd0)   r = cur - 8'd1;
    return r;
  endfunction

  function automatic gates_t decode_bridge(input dir_e dir, input logic on);
    gates_t g;
    g = '0;
    case (dir)
      DIR_FWD: begin
        g.hs_a = on;
        g.ls_a = !on;
        g.ls_b = 1'b1;
      end
      DIR_REV: begin
        g.hs_b = on;
        g.ls_b = !on;
        g.ls_a = 1'b1;
      end
      DIR_BRAKE: begin
        g.ls_a = 1'b1;
        g.ls_b = 1'b1;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase #(
  parameter int CNT_W    = 9,
  parameter int PER_FAST = 200,
  parameter int PER_SLOW = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freq_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per,
  output logic             period_end
);
  localparam logic [CNT_W-1:0] PER_F = CNT_W'(PER_FAST);
  localparam logic [CNT_W-1:0] PER_S = CNT_W'(PER_SLOW);

  assign period_end = (cnt == per - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      per <= PER_F;
    end else if (period_end) begin
      cnt <= '0;
      per <= freq_sel ? PER_S : PER_F;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hbpwm_duty_loop.sv
module hbpwm_duty_loop
  import hbpwm_pkg::*;
#(
  parameter int DUTY_W = 6,
  parameter int SMP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_end,
  input  logic              reg_mode,
  input  logic [DUTY_W-1:0] man_duty,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  vout_avg,
  input  logic [SMP_W-1:0]  vsupply,
  input  logic [SMP_W-1:0]  vtarget,
  output logic [DUTY_W-1:0] duty_q,
  output logic [DUTY_W-1:0] loop_duty,
  output logic              full_q,
  output step_e             step_q
);
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;
  localparam logic [DUTY_W-1:0] DMAX = DUTY_W'(DUTY_MAX);

  logic              taken_q;
  step_e             smp_step;
  logic [DUTY_W-1:0] loop_next;

  assign smp_step  = cmp_step(16'(vout_avg), 16'(vtarget));
  assign loop_next = DUTY_W'(sat_step(8'(loop_duty), step_q, 8'(DUTY_MAX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q    <= '0;
      loop_duty <= '0;
      full_q    <= 1'b0;
      taken_q   <= 1'b0;
      step_q    <= STEP_HOLD;
    end else begin
      if (smp_valid) full_q <= (vtarget > vsupply);
      if (period_end) begin
        if (reg_mode) begin
          if (full_q) begin
            duty_q <= DMAX;
          end else begin
            duty_q    <= loop_next;
            loop_duty <= loop_next;
          end
        end else begin
          duty_q    <= man_duty;
          loop_duty <= man_duty;
        end
        taken_q <= smp_valid;
        step_q  <= smp_valid ? smp_step : STEP_HOLD;
      end else if (smp_valid && !taken_q) begin
        taken_q <= 1'b1;
        step_q  <= smp_step;
      end
    end
  end
endmodule

// File: rtl/hbpwm_bridge_decode.sv
module hbpwm_bridge_decode
  import hbpwm_pkg::*;
(
  input  logic       dir_src,
  input  logic [1:0] pin_dir,
  input  logic [1:0] reg_dir,
  input  logic       pwm_on,
  output logic [1:0] dir_sel,
  output gates_t     gates
);
  assign dir_sel = dir_src ? reg_dir : pin_dir;
  assign gates   = decode_bridge(dir_e'(dir_sel), pwm_on);
endmodule

// File: rtl/hbridge_pwm_ctrl.sv
module hbridge_pwm_ctrl
  import hbpwm_pkg::*;
#(
  parameter int DUTY_W   = 6,
  parameter int SMP_W    = 10,
  parameter int PER_FAST = 200,
  parameter int PER_SLOW = 400,
  parameter int CNT_W    = $clog2(PER_SLOW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_sel,
  input  logic              reg_mode,
  input  logic [DUTY_W-1:0] man_duty,
  input  logic              dir_src,
  input  logic [1:0]        pin_dir,
  input  logic [1:0]        reg_dir,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  vout_avg,
  input  logic [SMP_W-1:0]  vsupply,
  input  logic [SMP_W-1:0]  vtarget,
  output logic              hs_a,
  output logic              ls_a,
  output logic              hs_b,
  output logic              ls_b,
  output logic              pwm_on,
  output logic [DUTY_W-1:0] duty_rd
);
  localparam logic [DUTY_W-1:0] DMAX = DUTY_W'((1 << DUTY_W) - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  per_q;
  logic              period_end;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] loop_duty;
  logic              full_q;
  step_e             step_q;
  logic [CNT_W-1:0]  on_cnt;
  logic [1:0]        dir_sel;
  gates_t            gates;

  hbpwm_timebase #(
    .CNT_W(CNT_W), .PER_FAST(PER_FAST), .PER_SLOW(PER_SLOW)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel),
    .cnt(cnt), .per(per_q), .period_end(period_end)
  );

  hbpwm_duty_loop #(.DUTY_W(DUTY_W), .SMP_W(SMP_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .period_end(period_end), .reg_mode(reg_mode),
    .man_duty(man_duty), .smp_valid(smp_valid), .vout_avg(vout_avg),
    .vsupply(vsupply), .vtarget(vtarget), .duty_q(duty_q),
    .loop_duty(loop_duty), .full_q(full_q), .step_q(step_q)
  );

  assign on_cnt = CNT_W'(on_count(8'(duty_q), 16'(per_q), DUTY_W));
  assign pwm_on = (duty_q == DMAX) || (cnt < on_cnt);

  hbpwm_bridge_decode u_dec (
    .dir_src(dir_src), .pin_dir(pin_dir), .reg_dir(reg_dir),
    .pwm_on(pwm_on), .dir_sel(dir_sel), .gates(gates)
  );

  assign hs_a    = gates.hs_a;
  assign ls_a    = gates.ls_a;
  assign hs_b    = gates.hs_b;
  assign ls_b    = gates.ls_b;
  assign duty_rd = duty_q;
endmodule

// File: rtl/hbridge_pwm_ctrl_chk.sv
module hbridge_pwm_ctrl_chk #(
  parameter int DUTY_W = 6,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_mode,
  input logic [1:0]        dir_sel,
  input logic              hs_a,
  input logic              ls_a,
  input logic              hs_b,
  input logic              ls_b,
  input logic              pwm_on,
  input logic [DUTY_W-1:0] duty_rd,
  input logic              period_end,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per_q,
  input logic [DUTY_W-1:0] loop_duty,
  input logic              full_q
);
  localparam logic [DUTY_W-1:0] DMAX = DUTY_W'((1 << DUTY_W) - 1);

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a) && !(hs_b && ls_b)); // R14

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < per_q); // R1

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(duty_rd)); // R4

  AST_FULL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && full_q && period_end) |=> duty_rd == DMAX); // R11

  AST_LOOP_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !full_q && period_end) |=>
      (loop_duty == $past(loop_duty)) ||
      (loop_duty == $past(loop_duty) + DUTY_W'(1)) ||
      (loop_duty == $past(loop_duty) - DUTY_W'(1))); // R9

  AST_FULL_DUTY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    duty_rd == DMAX |-> pwm_on); // R3

  AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    dir_sel == 2'b00 |-> !(hs_a || ls_a || hs_b || ls_b)); // R8
endmodule

bind hbridge_pwm_ctrl hbridge_pwm_ctrl_chk #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_mode(reg_mode), .dir_sel(dir_sel),
  .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .pwm_on(pwm_on),
  .duty_rd(duty_rd), .period_end(period_end), .cnt(cnt), .per_q(per_q),
  .loop_duty(loop_duty), .full_q(full_q)
);

// File: tb/hbridge_pwm_ctrl_tb.sv
module hbridge_pwm_ctrl_tb;
  localparam int CLK_PERIOD = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       freq_sel = 1'b0, reg_mode = 1'b0, dir_src = 1'b0, smp_valid = 1'b0;
  logic [5:0] man_duty = '0;
  logic [1:0] pin_dir = '0, reg_dir = '0;
  logic [9:0] vout_avg = '0, vsupply = '0, vtarget = '0;
  logic       hs_a, ls_a, hs_b, ls_b, pwm_on;
  logic [5:0] duty_rd;

  int n_checks = 0, n_errs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_pwm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .reg_mode(reg_mode),
    .man_duty(man_duty), .dir_src(dir_src), .pin_dir(pin_dir), .reg_dir(reg_dir),
    .smp_valid(smp_valid), .vout_avg(vout_avg), .vsupply(vsupply), .vtarget(vtarget),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .pwm_on(pwm_on), .duty_rd(duty_rd)
  );

  // reference state built from the requirements
  int m_cnt, m_per, m_duty, m_loop, m_step;
  bit m_full, m_taken;

  function automatic int exp_step(int avg, int tgt);
    if (avg < tgt) return 1;
    if (avg > tgt) return -1;
    return 0;
  endfunction

  function automatic bit exp_on(int d, int c, int p);
    if (d == 63) return 1'b1;
    return c < (d * p) / 64;
  endfunction

  // expected {hs_a, ls_a, hs_b, ls_b}
  function automatic logic [3:0] exp_gates(logic [1:0] d, bit on);
    case (d)
      2'b10:   return on ? 4'b1001 : 4'b0101;
      2'b01:   return on ? 4'b0110 : 4'b0101;
      2'b11:   return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 200; m_duty = 0; m_loop = 0; m_step = 0;
      m_full = 0; m_taken = 0;
    end else begin
      bit pend_full;
      pend_full = m_full;
      if (smp_valid) pend_full = (vtarget > vsupply);
      if (m_cnt == m_per - 1) begin
        if (reg_mode) begin
          if (m_full) m_duty = 63;
          else begin
            m_loop = m_loop + m_step;
            if (m_loop > 63) m_loop = 63;
            if (m_loop < 0) m_loop = 0;
            m_duty = m_loop;
          end
        end else begin
          m_duty = man_duty; m_loop = man_duty;
        end
        m_taken = smp_valid;
        m_step = smp_valid ? exp_step(vout_avg, vtarget) : 0;
        m_cnt = 0;
        m_per = freq_sel ? 400 : 200;
      end else begin
        m_cnt++;
        if (smp_valid && !m_taken) begin
          m_taken = 1; m_step = exp_step(vout_avg, vtarget);
        end
      end
      m_full = pend_full;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // every-cycle comparison, sampled after the inputs settle
  bit cyc_en = 0;
  always begin
    @(negedge clk); #1;
    if (cyc_en && rst_n) begin
      logic [1:0] d;
      bit eon;
      d = dir_src ? reg_dir : pin_dir;
      eon = exp_on(m_duty, m_cnt, m_per);
      check(duty_rd == 6'(m_duty), "R4 R9 R10 R11 R12 duty_rd", duty_rd, m_duty);
      check(pwm_on == eon, "R1 R2 R3 pwm_on", pwm_on, eon);
      check({hs_a, ls_a, hs_b, ls_b} == exp_gates(d, eon), "R5 R6 R7 R8 R14 gates",
            {hs_a, ls_a, hs_b, ls_b}, exp_gates(d, eon));
    end
  end

  task automatic sync_start();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
    #2;
  endtask

  task automatic count_on(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); #2;
      if (pwm_on) n++;
    end
  endtask

  task automatic pulse_sample(int avg, int sup, int tgt);
    @(negedge clk);
    vout_avg = 10'(avg); vsupply = 10'(sup); vtarget = 10'(tgt); smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int n, held;
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    #2;
    check(duty_rd == 0, "R13 reset duty", duty_rd, 0);
    check(pwm_on == 0, "R13 reset pwm", pwm_on, 0);
    @(negedge clk); rst_n = 1;
    cyc_en = 1;
    #2;
    check(duty_rd == 0 && pwm_on == 0, "R13 after reset", duty_rd, 0);

    // R2 half duty at both frequencies, forward via pins
    pin_dir = 2'b10; man_duty = 6'd31;
    sync_start(); sync_start();
    count_on(200, n); check(n == 96, "R2 duty31 fast", n, 96);
    freq_sel = 1; sync_start(); sync_start();
    count_on(400, n); check(n == 193, "R1 R2 duty31 slow", n, 193);
    // R3 extremes
    man_duty = 6'd63; sync_start(); sync_start();
    count_on(400, n); check(n == 400, "R3 duty63 full", n, 400);
    man_duty = 6'd0; sync_start(); sync_start();
    count_on(400, n); check(n == 0, "R3 duty0 off", n, 0);
    freq_sel = 0;
    // R5 R8 register source brake, then coast
    man_duty = 6'd20; dir_src = 1; reg_dir = 2'b11; pin_dir = 2'b10;
    sync_start();
    check({hs_a, ls_a, hs_b, ls_b} == 4'b0101, "R5 R8 brake on reg", {hs_a, ls_a, hs_b, ls_b}, 5);
    reg_dir = 2'b00; #1;
    check({hs_a, ls_a, hs_b, ls_b} == 4'b0000, "R8 coast", {hs_a, ls_a, hs_b, ls_b}, 0);
    dir_src = 0; pin_dir = 2'b01;

    // R9 R12 regulation from duty 20
    reg_mode = 1; man_duty = 6'd50;
    sync_start();
    check(duty_rd == 20, "R12 loop starts at manual duty", duty_rd, 20);
    pulse_sample(100, 900, 300); sync_start();
    check(duty_rd == 21, "R9 step up", duty_rd, 21);
    pulse_sample(500, 900, 300); pulse_sample(100, 900, 300); sync_start();
    check(duty_rd == 20, "R9 first sample wins, step down", duty_rd, 20);
    pulse_sample(300, 900, 300); sync_start();
    check(duty_rd == 20, "R9 equal holds", duty_rd, 20);
    sync_start();
    check(duty_rd == 20, "R12 manual ignored in regulation", duty_rd, 20);
    // R11 fallback and resume
    pulse_sample(100, 200, 300); sync_start();
    check(duty_rd == 63, "R11 target above supply", duty_rd, 63);
    pulse_sample(100, 200, 300); sync_start();
    check(duty_rd == 63, "R11 stays full", duty_rd, 63);
    pulse_sample(100, 900, 300); sync_start();
    check(duty_rd == 21, "R11 resume from held", duty_rd, 21);
    // R10 saturation
    reg_mode = 0; man_duty = 6'd63; sync_start(); sync_start();
    reg_mode = 1; pulse_sample(10, 900, 800); sync_start();
    check(duty_rd == 63, "R10 saturate high", duty_rd, 63);
    reg_mode = 0; man_duty = 6'd0; sync_start(); sync_start();
    reg_mode = 1; pulse_sample(800, 900, 10); sync_start();
    check(duty_rd == 0, "R10 saturate low", duty_rd, 0);
    held = 0;

    // random mix checked every cycle against the reference
    for (int it = 0; it < 120; it++) begin
      @(negedge clk);
      freq_sel = 1'($urandom);
      reg_mode = ($urandom % 3) == 0;
      man_duty = 6'($urandom);
      dir_src  = 1'($urandom);
      pin_dir  = 2'($urandom);
      reg_dir  = 2'($urandom);
      vsupply  = 10'($urandom);
      vtarget  = 10'($urandom % 1024);
      for (int k = 0; k < 50 + int'($urandom % 450); k++) begin
        @(negedge clk);
        smp_valid = ($urandom % 37) == 0;
        vout_avg = 10'($urandom);
      end
      smp_valid = 0;
    end
    cyc_en = 0;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule